// File: doc/BRIEF.md
# Stereo Envelope and Pan Mixer for Sign-Magnitude PCM

This block turns a stream of per-channel 8-bit PCM samples into one stereo output pair per frame. Each sample uses sign-magnitude coding. It is scaled by the channel's 8-bit envelope level, then split into a left and a right share by two 4-bit gain nibbles. Both shares are summed into saturating signed 16-bit accumulators.

A sequencer upstream presents one channel per cycle with `smp_valid` high, and raises `frame_done` together with the last channel of the frame. One cycle later the block presents the finished pair with a one-cycle `out_valid` and starts the next frame from zero. `mix_clear` discards whatever has been accumulated, for example when playback is switched off.

Top module: `pcm_stereo_mixer`

## Requirements
- R1: The sample magnitude is `smp_byte[6:0]`. Bit 7 set means positive and bit 7 clear means negative, so 0x00 and 0x80 both give zero.
- R2: The left share is (signed sample × `env_level` × `pan_gain[7:4]`) shifted arithmetically right by 5, which rounds toward minus infinity. The right share is formed the same way from `pan_gain[3:0]`. The arithmetic is exact before any clamping.
- R3: Shares are added only in cycles with `smp_valid` high. Inputs in cycles with `smp_valid` low have no effect on the emitted pair.
- R4: Each addition into an accumulator saturates to the range -32768..32767. A later addition of the opposite sign starts from the clamped value.
- R5: The pair emitted for a frame includes the share presented in the `frame_done` cycle. `out_left`/`out_right` update, and `out_valid` is high, in exactly the cycle after each `frame_done` cycle. `out_valid` is low in every other cycle.
- R6: After a `frame_done` cycle both accumulators restart from zero.
- R7: `mix_clear` zeroes both accumulators and drops the share of its own cycle. When it coincides with `frame_done`, the emitted pair is zero.
- R8: While `rst_n` is low, the outputs, `out_valid` and the accumulators are all zero.
- R9: `out_left` and `out_right` hold their value until the next emitted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Channel sample present this cycle |
| smp_byte | input | 8 | Sign-magnitude sample |
| env_level | input | 8 | Unsigned envelope level |
| pan_gain | input | 8 | Left gain in [7:4], right gain in [3:0] |
| frame_done | input | 1 | Last channel of the frame |
| mix_clear | input | 1 | Discard accumulated frame |
| out_left | output | 16 | Signed left output sample |
| out_right | output | 16 | Signed right output sample |
| out_valid | output | 1 | One-cycle strobe for a new output pair |

## Verification
Single-channel frames check the decode and scaling. They cover positive and negative full scale, both encodings of zero, a one-step negative value whose shift yields -1 rather than 0, and a tiny positive value that shifts to 0. Asymmetric gain nibbles tell left apart from right. Multi-channel frames distinguish summation from overwrite. Full-scale frames of each sign show clamping, and a clamp followed by an opposite-signed share separates saturation from wrap-around. Back-to-back frames, idle cycles with large inputs, and clears placed mid-frame or on the closing cycle check that stale state never leaks into a pair.

// File: rtl/pcm_stereo_mixer.sv
module pcm_stereo_mixer #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [7:0]       smp_byte,
  input  logic [7:0]       env_level,
  input  logic [7:0]       pan_gain,
  input  logic             frame_done,
  input  logic             mix_clear,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right,
  output logic             out_valid
);
  localparam int PROD_W = OUT_W + 7;
  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((64'd1 << (OUT_W-1)) - 64'd1);
  localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - PROD_W'(1);

  logic signed [OUT_W-1:0] acc_l, acc_r;

  logic [PROD_W-1:0] mag_ext;
  logic signed [PROD_W-1:0] sval, env_ext, gl_ext, gr_ext, env_val;
  logic signed [PROD_W-1:0] share_l, share_r, sum_l, sum_r;
  logic signed [OUT_W-1:0]  sat_l, sat_r, pair_l, pair_r;

  assign mag_ext = {{(PROD_W-7){1'b0}}, smp_byte[6:0]};
  assign sval    = smp_byte[7] ? $signed(mag_ext) : -$signed(mag_ext);
  assign env_ext = $signed({{(PROD_W-8){1'b0}}, env_level});
  assign gl_ext  = $signed({{(PROD_W-4){1'b0}}, pan_gain[7:4]});
  assign gr_ext  = $signed({{(PROD_W-4){1'b0}}, pan_gain[3:0]});
  assign env_val = sval * env_ext;
  assign share_l = (env_val * gl_ext) >>> 5;
  assign share_r = (env_val * gr_ext) >>> 5;

  assign sum_l = $signed({{(PROD_W-OUT_W){acc_l[OUT_W-1]}}, acc_l}) + (smp_valid ? share_l : '0);
  assign sum_r = $signed({{(PROD_W-OUT_W){acc_r[OUT_W-1]}}, acc_r}) + (smp_valid ? share_r : '0);

  function automatic logic signed [OUT_W-1:0] clamp(input logic signed [PROD_W-1:0] v);
    if (v > SAT_HI)      return SAT_HI[OUT_W-1:0];
    else if (v < SAT_LO) return SAT_LO[OUT_W-1:0];
    else                 return v[OUT_W-1:0];
  endfunction

  assign sat_l  = clamp(sum_l);
  assign sat_r  = clamp(sum_r);
  assign pair_l = mix_clear ? '0 : sat_l;
  assign pair_r = mix_clear ? '0 : sat_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_l     <= '0;
      acc_r     <= '0;
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= frame_done;
      if (frame_done) begin
        out_left  <= pair_l;
        out_right <= pair_r;
      end
      if (mix_clear || frame_done) begin
        acc_l <= '0;
        acc_r <= '0;
      end else begin
        acc_l <= sat_l;
        acc_r <= sat_r;
      end
    end
  end

  assert_strobe_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> out_valid);
  assert_strobe_only_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> !out_valid);
  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (acc_l == '0 && acc_r == '0));
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mix_clear |=> (acc_l == '0 && acc_r == '0));
  assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ($stable(out_left) && $stable(out_right)));
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !mix_clear && !frame_done && share_l >= 0 && acc_l >= 0) |=> acc_l >= 0);

  always_comb begin
    assert_share_range_R2: assert (share_l <= SAT_HI && share_l >= SAT_LO && share_r <= SAT_HI && share_r >= SAT_LO);
  end
endmodule

// File: tb/test_pcm_stereo_mixer.sv
`timescale 1ns/100ps
module test_pcm_stereo_mixer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, frame_done = 1'b0, mix_clear = 1'b0;
  logic [7:0] smp_byte = '0, env_level = '0, pan_gain = '0;
  logic [15:0] out_left, out_right;
  logic out_valid;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pcm_stereo_mixer i_pcm_stereo_mixer (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_byte(smp_byte),
    .env_level(env_level), .pan_gain(pan_gain), .frame_done(frame_done),
    .mix_clear(mix_clear), .out_left(out_left), .out_right(out_right),
    .out_valid(out_valid));

  // {sample, envelope, pan, expected left, expected right}
  localparam logic [55:0] VEC [9] = '{
    {8'hFF, 8'hFF, 8'hFF, 16'h3B4C, 16'h3B4C},
    {8'h7F, 8'hFF, 8'hFF, 16'hC4B3, 16'hC4B3},
    {8'h81, 8'h01, 8'h10, 16'h0000, 16'h0000},
    {8'h01, 8'h01, 8'h1F, 16'hFFFF, 16'hFFFF},
    {8'h90, 8'h40, 8'h83, 16'h0100, 16'h0060},
    {8'h00, 8'hFF, 8'hFF, 16'h0000, 16'h0000},
    {8'h80, 8'hFF, 8'hFF, 16'h0000, 16'h0000},
    {8'h20, 8'h10, 8'h2A, 16'hFFE0, 16'hFF60},
    {8'hFF, 8'hFF, 8'h00, 16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] s, input logic [7:0] e, input logic [7:0] p,
                       input logic v, input logic fd, input logic clr);
    @(negedge clk);
    smp_byte = s; env_level = e; pan_gain = p;
    smp_valid = v; frame_done = fd; mix_clear = clr;
  endtask

  task automatic idle_and_check(input string tag, input logic [15:0] el, input logic [15:0] er);
    @(negedge clk);
    smp_valid = 0; frame_done = 0; mix_clear = 0;
    chk({tag, " valid"}, {15'd0, out_valid}, 16'd1);
    chk({tag, " left"}, out_left, el);
    chk({tag, " right"}, out_right, er);
  endtask

  task automatic frame(input int n, input logic [7:0] s, input logic [7:0] e, input logic [7:0] p);
    for (int k = 0; k < n; k++) drive(s, e, p, 1'b1, k == n-1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset left", out_left, 16'h0);
    chk("R8 reset right", out_right, 16'h0);
    chk("R8 reset valid", {15'd0, out_valid}, 16'h0);
    rst_n = 1'b1;

    // R1 and R2: single-channel frames from the table
    for (int i = 0; i < 9; i++) begin
      frame(1, VEC[i][55:48], VEC[i][47:40], VEC[i][39:32]);
      idle_and_check($sformatf("R1/R2 vec%0d", i), VEC[i][31:16], VEC[i][15:0]);
    end
    @(negedge clk);
    chk("R5 valid single cycle", {15'd0, out_valid}, 16'h0);

    // R3: summation over eight channels
    frame(8, 8'h90, 8'h40, 8'h83);
    idle_and_check("R3 sum of eight", 16'h0800, 16'h0300);

    // R3: invalid cycles ignored
    drive(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
    drive(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
    drive(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0);
    idle_and_check("R3 invalid ignored", 16'h0000, 16'h0000);

    // R4: saturation both ways, and no wrap
    frame(8, 8'hFF, 8'hFF, 8'hFF);
    idle_and_check("R4 positive clamp", 16'h7FFF, 16'h7FFF);
    frame(8, 8'h7F, 8'hFF, 8'hFF);
    idle_and_check("R4 negative clamp", 16'h8000, 16'h8000);
    drive(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
    drive(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
    drive(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
    drive(8'h7F, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0);
    idle_and_check("R4 clamp then reverse", 16'h44B2, 16'h44B2);

    // R6: back-to-back frames restart from zero
    frame(2, 8'h90, 8'h40, 8'h83);
    chk("R6 first of pair valid", {15'd0, out_valid}, 16'h0);
    drive(8'h90, 8'h40, 8'h83, 1'b1, 1'b1, 1'b0);
    chk("R5 pair a left", out_left, 16'h0200);
    chk("R5 pair a valid", {15'd0, out_valid}, 16'h1);
    idle_and_check("R6 restart", 16'h0100, 16'h0060);

    // R9: outputs hold while a frame accumulates
    drive(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
    drive(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 hold left", out_left, 16'h0100);
    chk("R9 hold right", out_right, 16'h0060);
    chk("R5 no strobe mid-frame", {15'd0, out_valid}, 16'h0);

    // R7: clear mid-frame drops history and its own share
    drive(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1);
    frame(1, 8'h90, 8'h40, 8'h83);
    idle_and_check("R7 clear mid-frame", 16'h0100, 16'h0060);

    // R7: clear on the closing cycle emits zero
    drive(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
    drive(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1);
    idle_and_check("R7 clear at frame end", 16'h0000, 16'h0000);

    // R8: reset mid-frame clears accumulators
    drive(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    smp_valid = 0; rst_n = 0;
    @(negedge clk);
    chk("R8 reset out", out_left, 16'h0);
    rst_n = 1;
    frame(1, 8'h90, 8'h40, 8'h83);
    idle_and_check("R8 after reset", 16'h0100, 16'h0060);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule